// File: doc/BRIEF.md
# Tag-Triggered Operation Table

This block sits inside a network interface and holds a small table of prepared network operations. A host registers each row ahead of time with a tag, a threshold count and an opaque 32-bit operation descriptor. A compute device later announces progress by writing tag values to a single trigger port. Every write is compared against all live rows. Each row whose tag matches counts the write. Once a row's count reaches its threshold, the row hands its descriptor to an issue queue, and the engine behind the queue then carries out the operation.

Because release is driven by counting against a threshold, the producer can signal at any granularity. Many per-thread writes of one tag can be folded into a single operation, and a separate tag per thread group gives a separate operation for each group. Released descriptors pass through a small FIFO that has a ready/valid output. A row fires once and then retires until it is registered again.

Top module: `trig_op_table`

## Requirements
- R1: After reset the issue output is not valid, the unmatched flag is clear, and no row is live, so the first trigger write sets the unmatched flag.
- R2: A registration write (`reg_valid`, row selected by `reg_index`) makes that row live and loads its tag, threshold and descriptor, with the count at zero.
- R3: A trigger write whose tag equals the tag of a live row adds one to that row's count. The count saturates at its maximum and never wraps.
- R4: A live row whose count is greater than or equal to its threshold is released. Its descriptor becomes visible on the issue output on the clock edge after the edge where the condition first holds. A threshold of zero therefore releases a row one edge after it is registered, with no trigger write.
- R5: A row releases once. It then stops being live, and later writes of its tag neither count nor issue until the row is registered again. Because no live row matches such a write, the unmatched flag sets.
- R6: A trigger write that matches no live row is dropped and sets the unmatched flag. The flag stays set until reset.
- R7: All live rows that share a tag count the same write. When several rows are eligible, at most one enters the queue per cycle, with the lowest row index first.
- R8: The queue holds 4 descriptors. Whether it is full is judged before that cycle's pop. While it is full, eligible rows wait and keep counting, and they stay eligible however many further writes arrive.
- R9: While `issue_valid` is high and `issue_ready` is low, `issue_valid` stays high and `issue_desc` does not change. Descriptors leave the queue in the order they entered it.
- R10: When a registration and a matching trigger write address the same row in the same cycle, the registration wins and the row's count is zero afterwards.
- R11: A tag written N times to a row with threshold N gives exactly one operation. Distinct tags formed as base plus index give one operation per tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Registration write strobe |
| reg_index | input | 4 | Row selected by the registration |
| reg_tag | input | 16 | Tag to store |
| reg_thresh | input | 8 | Count needed for release |
| reg_desc | input | 32 | Operation descriptor to store |
| trig_valid | input | 1 | Trigger write strobe |
| trig_tag | input | 16 | Tag carried by the trigger write |
| issue_valid | output | 1 | A released descriptor is offered |
| issue_ready | input | 1 | Consumer accepts the offered descriptor |
| issue_desc | output | 32 | Offered descriptor |
| unmatched_flag | output | 1 | Sticky: a trigger write matched no live row |

## Verification
The hardest case to reach is a row that becomes eligible while the queue is full and then receives so many more writes that an unguarded count would wrap below its threshold. The stimulus holds `issue_ready` low and fills the queue with zero-threshold registrations, which release without any trigger. It then drives 300 writes at a threshold-one row before letting the queue drain. Shared-tag rows that become eligible on the same edge, and a registration that collides with a trigger on the same row, are staged directly. A long mixed phase with random ready, random row indices and a small tag set then drives these collisions at random, and a behavioural model checks every cycle.

// File: rtl/tot_pkg.sv
package tot_pkg;
   localparam int unsigned TOT_ENTRIES_DEF = 16;
   localparam int unsigned TOT_TAG_W_DEF   = 16;
   localparam int unsigned TOT_CNT_W_DEF   = 8;
   localparam int unsigned TOT_DESC_W_DEF  = 32;
   localparam int unsigned TOT_QDEPTH_DEF  = 4;
endpackage

// File: rtl/tot_entry.sv
module tot_entry #(
   parameter int unsigned TAG_W  = tot_pkg::TOT_TAG_W_DEF,
   parameter int unsigned CNT_W  = tot_pkg::TOT_CNT_W_DEF,
   parameter int unsigned DESC_W = tot_pkg::TOT_DESC_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TAG_W-1:0]  load_tag,
   input  logic [CNT_W-1:0]  load_thresh,
   input  logic [DESC_W-1:0] load_desc,
   input  logic              trig_valid,
   input  logic [TAG_W-1:0]  trig_tag,
   input  logic              retire,
   output logic              hit,
   output logic              eligible,
   output logic [DESC_W-1:0] desc
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic              live_q;
   logic [TAG_W-1:0]  tag_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  thr_q;
   logic [DESC_W-1:0] desc_q;

   assign hit      = live_q && (tag_q == trig_tag);
   assign eligible = live_q && (cnt_q >= thr_q);
   assign desc     = desc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         tag_q  <= '0;
         cnt_q  <= '0;
         thr_q  <= '0;
         desc_q <= '0;
      end else if (load) begin
         live_q <= 1'b1;
         tag_q  <= load_tag;
         cnt_q  <= '0;
         thr_q  <= load_thresh;
         desc_q <= load_desc;
      end else begin
         if (retire) live_q <= 1'b0;
         if (trig_valid && hit && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3
   cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !load) |=> (cnt_q >= $past(cnt_q)));

   // R8
   stays_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eligible && !retire && !load) |=> eligible);
endmodule

// File: rtl/tot_pick.sv
module tot_pick #(
   parameter int unsigned N = tot_pkg::TOT_ENTRIES_DEF
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
      any = taken;
   end
endmodule

// File: rtl/tot_fifo.sv
module tot_fifo #(
   parameter int unsigned W     = tot_pkg::TOT_DESC_W_DEF,
   parameter int unsigned DEPTH = tot_pkg::TOT_QDEPTH_DEF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   output logic         full,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW   = $clog2(DEPTH + 1);
   localparam bit          POW2 = (DEPTH == (1 << PW));

   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("tot_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt_q;
   logic          pop;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_q + 1'b1;
         assign rd_nxt = rd_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign full      = (cnt_q == CW'(DEPTH));
   assign out_valid = (cnt_q != '0);
   assign out_data  = mem_q[rd_q];
   assign pop       = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_nxt;
         if (pop)  rd_q <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem_q[wr_q] <= push_data;
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q < CW'(DEPTH)));

   // R9
   issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/trig_op_table.sv
module trig_op_table #(
   parameter int unsigned ENTRIES = tot_pkg::TOT_ENTRIES_DEF,
   parameter int unsigned TAG_W   = tot_pkg::TOT_TAG_W_DEF,
   parameter int unsigned CNT_W   = tot_pkg::TOT_CNT_W_DEF,
   parameter int unsigned DESC_W  = tot_pkg::TOT_DESC_W_DEF,
   parameter int unsigned QDEPTH  = tot_pkg::TOT_QDEPTH_DEF,
   localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic [IDX_W-1:0]  reg_index,
   input  logic [TAG_W-1:0]  reg_tag,
   input  logic [CNT_W-1:0]  reg_thresh,
   input  logic [DESC_W-1:0] reg_desc,
   input  logic              trig_valid,
   input  logic [TAG_W-1:0]  trig_tag,
   output logic              issue_valid,
   input  logic              issue_ready,
   output logic [DESC_W-1:0] issue_desc,
   output logic              unmatched_flag
);
   generate
      if (ENTRIES < 2) begin : g_entries_bad
         $error("trig_op_table: ENTRIES must be at least 2");
      end
      if (TAG_W < 1 || CNT_W < 1 || DESC_W < 1) begin : g_width_bad
         $error("trig_op_table: field widths must be positive");
      end
   endgenerate

   logic [ENTRIES-1:0] hit_vec, elig_vec, gnt_vec, retire_vec;
   logic [DESC_W-1:0]  desc_vec [ENTRIES];
   logic               any_elig, q_full, q_push, flag_q;
   logic [DESC_W-1:0]  push_desc;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_row
      tot_entry #(.TAG_W(TAG_W), .CNT_W(CNT_W), .DESC_W(DESC_W)) u_row (
         .clk         (clk),
         .rst_n       (rst_n),
         .load        (reg_valid && (reg_index == IDX_W'(i))),
         .load_tag    (reg_tag),
         .load_thresh (reg_thresh),
         .load_desc   (reg_desc),
         .trig_valid  (trig_valid),
         .trig_tag    (trig_tag),
         .retire      (retire_vec[i]),
         .hit         (hit_vec[i]),
         .eligible    (elig_vec[i]),
         .desc        (desc_vec[i])
      );
   end

   tot_pick #(.N(ENTRIES)) u_pick (
      .req (elig_vec),
      .gnt (gnt_vec),
      .any (any_elig)
   );

   assign q_push     = any_elig && !q_full;
   assign retire_vec = gnt_vec & {ENTRIES{q_push}};

   always_comb begin
      push_desc = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         push_desc = push_desc | (desc_vec[i] & {DESC_W{gnt_vec[i]}});
      end
   end

   tot_fifo #(.W(DESC_W), .DEPTH(QDEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (push_desc),
      .full      (q_full),
      .out_valid (issue_valid),
      .out_ready (issue_ready),
      .out_data  (issue_desc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q <= 1'b0;
      else if (trig_valid && !(|hit_vec)) flag_q <= 1'b1;
   end
   assign unmatched_flag = flag_q;

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unmatched_flag |=> unmatched_flag);

   // R7
   one_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(retire_vec));

   // R7
   lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_vec != '0) |-> ((elig_vec & (retire_vec - 1'b1)) == '0));

   // R8
   full_defers_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> (retire_vec == '0));

   // R4
   release_only_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((retire_vec & ~elig_vec) == '0));
endmodule

// File: tb/trig_op_table_tb.sv
module trig_op_table_tb;
   localparam int NE = 16;
   localparam int QD = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic [3:0]  reg_index = '0;
   logic [15:0] reg_tag = '0;
   logic [7:0]  reg_thresh = '0;
   logic [31:0] reg_desc = '0;
   logic        trig_valid = 1'b0;
   logic [15:0] trig_tag = '0;
   logic        issue_ready = 1'b0;
   logic        issue_valid;
   logic [31:0] issue_desc;
   logic        unmatched_flag;

   always #2.5 clk = ~clk;

   trig_op_table u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_valid(reg_valid), .reg_index(reg_index), .reg_tag(reg_tag),
      .reg_thresh(reg_thresh), .reg_desc(reg_desc),
      .trig_valid(trig_valid), .trig_tag(trig_tag),
      .issue_valid(issue_valid), .issue_ready(issue_ready),
      .issue_desc(issue_desc), .unmatched_flag(unmatched_flag)
   );

   int    n_checks = 0;
   int    n_fails  = 0;
   int    n_cycles = 0;
   bit    done     = 1'b0;
   string cur_req  = "R1";

   // behavioural reference
   bit        m_live [NE];
   int        m_tag  [NE];
   int        m_cnt  [NE];
   int        m_thr  [NE];
   bit [31:0] m_desc [NE];
   bit [31:0] m_q [$];
   bit        m_flag;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, n_cycles);
      end
   endtask

   always @(posedge clk) begin : model
      int  pk;
      bit  matched, can_push;
      if (!rst_n) begin
         for (int i = 0; i < NE; i++) begin
            m_live[i] = 0; m_cnt[i] = 0; m_thr[i] = 0; m_tag[i] = 0; m_desc[i] = '0;
         end
         m_q.delete();
         m_flag = 0;
      end else begin
         pk = -1;
         for (int i = NE - 1; i >= 0; i--)
            if (m_live[i] && m_cnt[i] >= m_thr[i]) pk = i;
         matched = 0;
         for (int i = 0; i < NE; i++)
            if (m_live[i] && m_tag[i] == int'(trig_tag)) matched = 1;
         can_push = (m_q.size() < QD);
         if (issue_ready && m_q.size() > 0) void'(m_q.pop_front());
         if (trig_valid)
            for (int i = 0; i < NE; i++)
               if (m_live[i] && m_tag[i] == int'(trig_tag) && m_cnt[i] < 255) m_cnt[i]++;
         if (pk >= 0 && can_push) begin
            m_q.push_back(m_desc[pk]);
            m_live[pk] = 0;
         end
         if (reg_valid) begin
            m_live[reg_index] = 1;
            m_tag[reg_index]  = int'(reg_tag);
            m_cnt[reg_index]  = 0;
            m_thr[reg_index]  = int'(reg_thresh);
            m_desc[reg_index] = reg_desc;
         end
         if (trig_valid && !matched) m_flag = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({cur_req, " issue_valid"}, {31'b0, issue_valid}, {31'b0, (m_q.size() > 0)});
         if (m_q.size() > 0) check({cur_req, " issue_desc"}, issue_desc, m_q[0]);
         check({cur_req, " unmatched_flag"}, {31'b0, unmatched_flag}, {31'b0, m_flag});
      end
   end

   always @(posedge clk) begin
      n_cycles++;
      if (n_cycles > 150000 && !done) begin
         done = 1;
         n_fails++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", n_cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk); #1;
      reg_valid  = 1'b0;
      trig_valid = 1'b0;
   endtask

   task automatic do_reg(input int idx, input int tag, input int thr, input bit [31:0] d);
      reg_valid = 1'b1; reg_index = 4'(idx); reg_tag = 16'(tag);
      reg_thresh = 8'(thr); reg_desc = d;
   endtask

   task automatic do_trig(input int tag);
      trig_valid = 1'b1; trig_tag = 16'(tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; reg_valid = 0; trig_valid = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      #1;
      check("R1 reset issue_valid", {31'b0, issue_valid}, 32'd0);
      check("R1 reset flag", {31'b0, unmatched_flag}, 32'd0);
      cur_req = "R1 R6";
      do_trig(16'h1234); step(); idle(2);
      check("R6 flag set", {31'b0, unmatched_flag}, 32'd1);
      do_reset();
      cur_req = "R6";
      step();
      check("R6 flag cleared by reset", {31'b0, unmatched_flag}, 32'd0);

      // R2 R4 R11: one tag written four times against threshold four
      cur_req = "R2 R4 R11";
      issue_ready = 1'b1;
      do_reg(3, 16'h0100, 4, 32'hA000_0003); step();
      for (int k = 0; k < 4; k++) begin do_trig(16'h0100); step(); end
      idle(4);

      // R11: base plus index tags
      cur_req = "R11";
      for (int k = 0; k < 3; k++) begin do_reg(5 + k, 16'h0200 + k, 1, 32'hB000_0000 + k); step(); end
      do_trig(16'h0201); step();
      do_trig(16'h0200); step();
      do_trig(16'h0202); step();
      idle(5);

      // R5: fired row ignores further writes
      do_reset();
      cur_req = "R5";
      do_reg(2, 16'h0300, 1, 32'hC000_0002); step();
      do_trig(16'h0300); step(); idle(3);
      do_trig(16'h0300); step(); idle(3);
      check("R5 flag after retired tag", {31'b0, unmatched_flag}, 32'd1);
      check("R5 no extra issue", {31'b0, issue_valid}, 32'd0);

      // R7: shared tag, lowest index first
      cur_req = "R7";
      issue_ready = 1'b0;
      do_reg(9, 16'h0400, 2, 32'hD000_0009); step();
      do_reg(4, 16'h0400, 2, 32'hD000_0004); step();
      do_trig(16'h0400); step();
      do_trig(16'h0400); step();
      idle(4);
      check("R7 first out is row 4", issue_desc, 32'hD000_0004);
      issue_ready = 1'b1;
      idle(4);

      // R8 R9 R4: full queue with zero-threshold rows, then a waiting row
      cur_req = "R8 R9 R4";
      issue_ready = 1'b0;
      do_reg(10, 16'h0510, 0, 32'hE000_000A); step();
      do_reg(11, 16'h0511, 0, 32'hE000_000B); step();
      do_reg(13, 16'h0513, 0, 32'hE000_000D); step();
      do_reg(14, 16'h0514, 0, 32'hE000_000E); step();
      do_reg(12, 16'h0500, 1, 32'hE000_000C); step();
      for (int k = 0; k < 300; k++) begin do_trig(16'h0500); step(); end
      check("R9 head held", issue_desc, 32'hE000_000A);
      issue_ready = 1'b1;
      idle(8);

      // R10: registration beats a same-row trigger
      cur_req = "R10";
      do_reg(1, 16'h0600, 2, 32'hF000_0001); step();
      do_trig(16'h0600); step();
      do_reg(1, 16'h0600, 2, 32'hF000_0011); do_trig(16'h0600); step();
      do_trig(16'h0600); step(); idle(3);
      check("R10 not yet released", {31'b0, issue_valid}, 32'd0);
      do_trig(16'h0600); step(); idle(1);
      check("R10 released after two fresh writes", issue_desc, 32'hF000_0011);
      idle(3);

      // mixed phase covering R3 R7 R8 R10 collisions
      cur_req = "R3 R7 R8 R10 mixed";
      for (int k = 0; k < 3000; k++) begin
         int r;
         r = int'($urandom_range(0, 99));
         issue_ready = ($urandom_range(0, 9) < 7);
         if (r < 35) do_reg(int'($urandom_range(0, 15)), 16'h0700 + int'($urandom_range(0, 5)),
                            int'($urandom_range(0, 3)), $urandom);
         if (r >= 20 && r < 80) do_trig(16'h0700 + int'($urandom_range(0, 6)));
         step();
      end
      issue_ready = 1'b1;
      idle(30);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule